// File: doc/BRIEF.md
# DMA Interrupt Status and Enable Unit

This unit gathers single-cycle event pulses from the transmit and receive DMA engines into a status register. A separate per-source enable register gates that status onto one interrupt line. Software reads both registers through a small register port. It acknowledges events by writing ones to the status bits it has handled. Bits written as zero keep their value.

The core sources fall into two groups. Each group is summarised by a read-only bit in the status register. The two transfer-complete sources form the normal group. The eleven error and exception sources form the abnormal group. The abnormal summary sits at bit 15 and the normal summary at bit 16. Two further optional sources are latched outside the core field. They are expected to stay disabled, but software can still clear them. All port outputs are registered.

Top module: `dmairq_unit`

## Requirements
- R1: After synchronous reset, the status register, the enable register, `irq_o`, `sum_abn_o` and `sum_nrm_o` are all zero.
- R2: A pulse on `evt_i[n]` sets status bit P(n), where P = {0,6,1,2,3,7,8,9,10,11,12,13,14,26,27} for n = 0..14. Sources 0 (transmit done) and 1 (receive done) are normal. Sources 2..12 are abnormal: transmit stopped, transmit no buffer, transmit jabber, receive no buffer, receive stopped, receive watchdog, early transmit, fatal bus error, transmit underflow, receive overflow, early receive. Sources 13 and 14 are optional.
- R3: Writing address 0 clears each source bit whose written data bit is 1. Source bits written with 0 keep their value.
- R4: An event that arrives in the same cycle as a clearing write to its bit leaves that bit set.
- R5: Status bit 15 and `sum_abn_o` are 1 exactly when at least one abnormal source bit is set. Writing 1 to bit 15 clears no member.
- R6: Status bit 16 and `sum_nrm_o` are 1 exactly when source 0 or source 1 is set. Writing 1 to bit 16 clears no member. The optional sources affect neither summary.
- R7: `irq_o` is 1 exactly when the bitwise AND of the status register (summary bits included) and the enable register is nonzero.
- R8: Each status position has its own enable bit at the same position. Writing address 1 stores the written data masked to the implemented positions, so one source can be disabled while the others keep interrupting.
- R9: The implemented positions are 0x0C01FFCF: the core field 0x1FFCF plus bits 26 and 27. Every other bit reads 0 in both registers, whatever was written.
- R10: Address 0 reads status, address 1 reads enable, and other addresses read 0. `reg_rdata_o` shows the addressed register as it stood before the clock edge that samples the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 15 | One-cycle event pulses, one per source |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address (0 status, 1 enable) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Registered interrupt request |
| sum_abn_o | output | 1 | Registered abnormal summary |
| sum_nrm_o | output | 1 | Registered normal summary |

## Verification
Events and register writes land in the internal registers at the edge that samples them. `irq_o`, both summary outputs and `reg_rdata_o` follow one edge later. Each check therefore holds the address steady across the edge after the stimulus and samples at the following falling edge. The bench sweeps every source alone and every pair of sources under a per-source enable. It keeps its expected registers in a model that reproduces the clear, the set-wins rule and the summary rules from the position table in the requirements.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
  localparam int REG_W   = 32;
  localparam int SRC_N   = 15;
  localparam int ABN_POS = 15;
  localparam int NRM_POS = 16;

  typedef enum logic [1:0] {CLS_NRM, CLS_ABN, CLS_OPT} src_class_e;

  function automatic int src_pos(input int i);
    case (i)
      0: return 0;   1: return 6;   2: return 1;   3: return 2;
      4: return 3;   5: return 7;   6: return 8;   7: return 9;
      8: return 10;  9: return 11;  10: return 12; 11: return 13;
      12: return 14; 13: return 26; default: return 27;
    endcase
  endfunction

  function automatic src_class_e src_class(input int i);
    if (i < 2) return CLS_NRM;
    else if (i < 13) return CLS_ABN;
    else return CLS_OPT;
  endfunction

  function automatic logic [SRC_N-1:0] class_sel(input src_class_e c);
    logic [SRC_N-1:0] m;
    m = '0;
    for (int i = 0; i < SRC_N; i++) if (src_class(i) == c) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [REG_W-1:0] valid_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < SRC_N; i++) m[src_pos(i)] = 1'b1;
    m[ABN_POS] = 1'b1;
    m[NRM_POS] = 1'b1;
    return m;
  endfunction

  localparam logic [SRC_N-1:0] ABN_SEL    = class_sel(CLS_ABN);
  localparam logic [SRC_N-1:0] NRM_SEL    = class_sel(CLS_NRM);
  localparam logic [REG_W-1:0] VALID_MASK = valid_mask();
endpackage

// File: rtl/dmairq_status.sv
module dmairq_status
  import dmairq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_N-1:0] evt_i,
  input  logic             clr_en_i,
  input  logic [SRC_N-1:0] clr_src_i,
  output logic [REG_W-1:0] stat_o,
  output logic             abn_o,
  output logic             nrm_o
);
  logic [SRC_N-1:0] src_q;

  for (genvar i = 0; i < SRC_N; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst) src_q[i] <= 1'b0;
      else if (evt_i[i]) src_q[i] <= 1'b1;
      else if (clr_en_i && clr_src_i[i]) src_q[i] <= 1'b0;
    end
  end

  assign abn_o = |(src_q & ABN_SEL);
  assign nrm_o = |(src_q & NRM_SEL);

  always_comb begin
    stat_o = '0;
    for (int i = 0; i < SRC_N; i++) stat_o[src_pos(i)] = src_q[i];
    stat_o[ABN_POS] = abn_o;
    stat_o[NRM_POS] = nrm_o;
  end

  // R4
  evt_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (|evt_i) |=> ((src_q & $past(evt_i)) == $past(evt_i)));
  // R3
  no_lost_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr_en_i) |=> ((src_q & $past(src_q)) == $past(src_q)));
  // R2
  spurious_set_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((src_q & ~$past(src_q) & ~$past(evt_i)) == '0));
endmodule

// File: rtl/dmairq_enable.sv
module dmairq_enable
  import dmairq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] en_o
);
  always_ff @(posedge clk) begin
    if (rst) en_o <= '0;
    else if (wr_i) en_o <= wdata_i & VALID_MASK;
  end

  // R9
  en_reserved_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((en_o & ~VALID_MASK) == '0));
endmodule

// File: rtl/dmairq_out.sv
module dmairq_out
  import dmairq_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_W-1:0]  stat_i,
  input  logic [REG_W-1:0]  en_i,
  input  logic              abn_i,
  input  logic              nrm_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              irq_o,
  output logic              abn_o,
  output logic              nrm_o
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
      irq_o   <= 1'b0;
      abn_o   <= 1'b0;
      nrm_o   <= 1'b0;
    end else begin
      irq_o <= |(stat_i & en_i);
      abn_o <= abn_i;
      nrm_o <= nrm_i;
      if (addr_i == A_STAT) rdata_o <= stat_i;
      else if (addr_i == A_EN) rdata_o <= en_i;
      else rdata_o <= '0;
    end
  end

  // R7
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (en_i == '0) |=> !irq_o);
  // R9
  rdata_reserved_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((rdata_o & ~VALID_MASK) == '0));
  // R5
  abn_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!stat_i[ABN_POS]) |=> !abn_o);
endmodule

// File: rtl/dmairq_unit.sv
module dmairq_unit
  import dmairq_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SRC_N-1:0]  evt_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              irq_o,
  output logic              sum_abn_o,
  output logic              sum_nrm_o
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(1);

  logic             wr_stat, wr_en, abn, nrm;
  logic [SRC_N-1:0] clr_src;
  logic [REG_W-1:0] stat, en;

  assign wr_stat = reg_wr_i && (reg_addr_i == A_STAT);
  assign wr_en   = reg_wr_i && (reg_addr_i == A_EN);

  always_comb begin
    for (int i = 0; i < SRC_N; i++) clr_src[i] = reg_wdata_i[src_pos(i)];
  end

  dmairq_status u_stat (
    .clk(clk), .rst(rst), .evt_i(evt_i), .clr_en_i(wr_stat),
    .clr_src_i(clr_src), .stat_o(stat), .abn_o(abn), .nrm_o(nrm)
  );

  dmairq_enable u_en (
    .clk(clk), .rst(rst), .wr_i(wr_en), .wdata_i(reg_wdata_i), .en_o(en)
  );

  dmairq_out #(.ADDR_W(ADDR_W)) u_out (
    .clk(clk), .rst(rst), .stat_i(stat), .en_i(en), .abn_i(abn), .nrm_i(nrm),
    .addr_i(reg_addr_i), .rdata_o(reg_rdata_o), .irq_o(irq_o),
    .abn_o(sum_abn_o), .nrm_o(sum_nrm_o)
  );
endmodule

// File: tb/sim_dmairq_unit.sv
module sim_dmairq_unit;
  localparam int CLK_P = 10;
  localparam int NS = 15;
  localparam logic [31:0] VALID = 32'h0C01FFCF;
  localparam logic [31:0] SUMB  = 32'h00018000;
  localparam int POS [NS] = '{0,6,1,2,3,7,8,9,10,11,12,13,14,26,27};

  logic clk = 1'b0, rst = 1'b1;
  logic [NS-1:0] evt = '0;
  logic wr = 1'b0;
  logic [1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq, sabn, snrm;

  int checks = 0, fails = 0;
  logic [NS-1:0] m_src = '0;
  logic [31:0] m_en = '0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  dmairq_unit u0 (.clk(clk), .rst(rst), .evt_i(evt), .reg_wr_i(wr),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_o(irq), .sum_abn_o(sabn), .sum_nrm_o(snrm));

  function automatic logic m_abn();
    return |m_src[12:2];
  endfunction
  function automatic logic m_nrm();
    return m_src[0] | m_src[1];
  endfunction
  function automatic logic [31:0] m_stat();
    logic [31:0] s = '0;
    for (int i = 0; i < NS; i++) s[POS[i]] = m_src[i];
    s[15] = m_abn();
    s[16] = m_nrm();
    return s;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(logic [NS-1:0] e, logic w, logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    evt = e; wr = w; addr = a; wdata = d;
    @(posedge clk);
    if (w && a == 2'd0)
      for (int i = 0; i < NS; i++) if (d[POS[i]]) m_src[i] = 1'b0;
    m_src = m_src | e;
    if (w && a == 2'd1) m_en = d & VALID;
    @(negedge clk);
    evt = '0; wr = 1'b0;
  endtask

  // reads both registers and checks outputs; one edge after the last stimulus
  task automatic check_all(string req);
    addr = 2'd0;
    @(posedge clk); @(negedge clk);
    chk(req, "status", rdata, m_stat());
    chk("R7", "irq", {31'd0, irq}, {31'd0, |(m_stat() & m_en)});
    chk("R5", "sum_abn", {31'd0, sabn}, {31'd0, m_abn()});
    chk("R6", "sum_nrm", {31'd0, snrm}, {31'd0, m_nrm()});
    addr = 2'd1;
    @(posedge clk); @(negedge clk);
    chk(req, "enable", rdata, m_en);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    check_all("R1");

    // every source alone
    for (int i = 0; i < NS; i++) begin
      step(NS'(1) << i, 1'b0, 2'd0, '0);
      check_all("R2");
      step('0, 1'b1, 2'd1, 32'd1 << POS[i]);
      check_all("R8");
      step('0, 1'b1, 2'd1, VALID & ~SUMB & ~(32'd1 << POS[i]));
      check_all("R8");
      step('0, 1'b1, 2'd0, SUMB);
      check_all("R5");
      step('0, 1'b1, 2'd0, ~(32'd1 << POS[i]));
      check_all("R3");
      step('0, 1'b1, 2'd0, 32'd1 << POS[i]);
      check_all("R9");
      step('0, 1'b1, 2'd1, '0);
    end

    // set wins over a same-cycle clear
    step(NS'(1) << 4, 1'b0, 2'd0, '0);
    step(NS'(1) << 4, 1'b1, 2'd0, 32'd1 << POS[4]);
    check_all("R4");
    step('0, 1'b1, 2'd0, 32'hFFFFFFFF);
    check_all("R3");

    // enable reserved bits and unmapped addresses
    step('0, 1'b1, 2'd1, 32'hFFFFFFFF);
    check_all("R9");
    for (int a = 2; a < 4; a++) begin
      addr = 2'(a);
      @(posedge clk); @(negedge clk);
      chk("R10", "unmapped", rdata, 32'd0);
    end
    step('0, 1'b1, 2'd1, '0);

    // pairs of sources with a single-source enable
    for (int a = 0; a < NS; a++)
      for (int b = 0; b < NS; b++) begin
        step((NS'(1) << a) | (NS'(1) << b), 1'b1, 2'd1, 32'd1 << POS[b]);
        check_all("R7");
        step('0, 1'b1, 2'd0, 32'hFFFFFFFF);
      end
    check_all("R6");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule